// File: doc/BRIEF.md
# Split-Access Transmit Pending Flag Register

This block holds one transmit-pending flag per message mailbox of a mailbox-based message controller. Software raises a flag to ask for a mailbox to be sent. The transmit engine reads the live flag vector from a dedicated output. A flag stays set while its transmission is waiting or in progress. Hardware clears it, either through a cancel-request vector or through a one-cycle transmission-done pulse for that mailbox.

Software reaches the 32-bit register over a 16-bit synchronous bus, as an upper word and a lower word. A single hidden holding latch makes a 32-bit access atomic when it arrives as two word accesses, upper word first.
- On a write, the upper word is parked in the latch. The following lower-word write then applies both halves in the same clock cycle.
- On a read, reading the upper word snapshots the lower half into the latch. The following lower-word read returns that snapshot.

Software can only set flags. Writing zero does nothing. Mailboxes that are not configured to transmit are masked by a direction vector, and the flag of mailbox 0 does not exist.

Top module: `txpend_split_reg`

## Requirements
- R1: After reset, every pending flag, the holding latch and `bus_rdata` are all zero.
- R2: A write with `bus_word`=0 (upper word, flags 31..16) goes only into the holding latch. `pend_flags` does not change.
- R3: A write with `bus_word`=1 (lower word, flags 15..0) takes the latch as bits 31..16 and `bus_wdata` as bits 15..0. Every 1 in that 32-bit value sets the matching flag, and all of them become visible together on `pend_flags` one cycle later.
- R4: A read with `bus_word`=0 returns flags 31..16 on `bus_rdata` one cycle later. In the same cycle it copies the current flags 15..0 into the holding latch.
- R5: A read with `bus_word`=1 returns the holding latch one cycle later, not the live flags 15..0.
- R6: Writing 0 to a flag position never clears a flag.
- R7: A 1 on `cancel_req[i]` clears flag i at the next clock edge.
- R8: A 1 on `tx_done[i]` clears flag i at the next clock edge.
- R9: When a set and a clear reach the same flag in the same cycle, the clear wins and the flag ends at 0.
- R10: Flag 0 (mailbox 0) always reads 0 on both `pend_flags` and `bus_rdata`, and writes to it are ignored.
- R11: A set of flag i is dropped when `tx_dir[i]` is 0.
- R12: `bus_rdata` changes only one cycle after a read strobe. At other times it holds its last value.
- R13: A strobe with `bus_cs`=0 has no effect: no flag, latch or read-data change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Chip select, qualifies the strobes |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_word | input | 1 | Word select: 0 = upper word (offset 0x020), 1 = lower word (offset 0x022) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| tx_dir | input | 32 | 1 = mailbox is configured to transmit |
| cancel_req | input | 32 | Per-mailbox cancel clear request |
| tx_done | input | 32 | Per-mailbox one-cycle transmission-done pulse |
| pend_flags | output | 32 | Live pending flag vector |

## Verification
The bench parks an upper-word write and checks that no flag moves until the lower write lands. A design that applied the upper half early would show a partially updated vector. Between an upper read and a lower read it clears a lower flag, so a design that read the live half instead of the snapshot returns the changed value. It drives a set and a cancel onto the same bit in one cycle, where a set-priority design leaves the flag high. It also writes zeros, writes mailbox 0, writes masked mailboxes and strobes with chip select low. In each of these cases a flawed design would drop, corrupt or invent flags.

// File: rtl/txpend_pkg.sv
package txpend_pkg;

   // word select encoding on the bus
   typedef enum logic {
      WORD_UPPER = 1'b0,
      WORD_LOWER = 1'b1
   } word_sel_e;

   // bus operation decoded from the strobes
   typedef enum logic [2:0] {
      OP_IDLE     = 3'd0,
      OP_WR_UPPER = 3'd1,
      OP_WR_LOWER = 3'd2,
      OP_RD_UPPER = 3'd3,
      OP_RD_LOWER = 3'd4
   } bus_op_e;

   function automatic bus_op_e decode_op(input logic cs, input logic rd,
                                         input logic wr, input logic word);
      bus_op_e op;
      op = OP_IDLE;
      if (cs && wr)
         op = (word == WORD_LOWER) ? OP_WR_LOWER : OP_WR_UPPER;
      else if (cs && rd)
         op = (word == WORD_LOWER) ? OP_RD_LOWER : OP_RD_UPPER;
      return op;
   endfunction

endpackage

// File: rtl/txpend_bus_port.sv
module txpend_bus_port
   import txpend_pkg::*;
#(
   parameter int FLAG_W = 32,
   localparam int HALF_W = FLAG_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_cs,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic              bus_word,
   input  logic [HALF_W-1:0] bus_wdata,
   input  logic [FLAG_W-1:0] flags,
   output logic [FLAG_W-1:0] set_vec,
   output logic              set_en,
   output logic [HALF_W-1:0] bus_rdata
);

   bus_op_e           op;
   logic [HALF_W-1:0] hold_q;
   logic [HALF_W-1:0] rdata_q;

   always_comb op = decode_op(bus_cs, bus_rd, bus_wr, bus_word);

   // shared holding latch: upper write parks data, upper read snapshots low half
   always_ff @(posedge clk) begin
      if (!rst_n)
         hold_q <= '0;
      else if (op == OP_WR_UPPER)
         hold_q <= bus_wdata;
      else if (op == OP_RD_UPPER)
         hold_q <= flags[HALF_W-1:0];
   end

   // registered read data, held between reads
   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (op == OP_RD_UPPER)
         rdata_q <= flags[FLAG_W-1:HALF_W];
      else if (op == OP_RD_LOWER)
         rdata_q <= hold_q;
   end

   always_comb begin
      set_en  = (op == OP_WR_LOWER);
      set_vec = {hold_q, bus_wdata};
   end

   assign bus_rdata = rdata_q;

endmodule

// File: rtl/txpend_flag_bank.sv
module txpend_flag_bank #(
   parameter int              FLAG_W  = 32,
   parameter logic [FLAG_W-1:0] PRESENT = 32'hFFFF_FFFE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic [FLAG_W-1:0] set_vec,
   input  logic [FLAG_W-1:0] dir_mask,
   input  logic [FLAG_W-1:0] clr_vec,
   output logic [FLAG_W-1:0] flags
);

   for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
      if (PRESENT[i]) begin : g_live
         logic flag_q;
         // clear has priority over set
         always_ff @(posedge clk) begin
            if (!rst_n)
               flag_q <= 1'b0;
            else if (clr_vec[i])
               flag_q <= 1'b0;
            else if (set_en && set_vec[i] && dir_mask[i])
               flag_q <= 1'b1;
         end
         assign flags[i] = flag_q;
      end else begin : g_tied
         assign flags[i] = 1'b0;
      end
   end

endmodule

// File: rtl/txpend_split_reg.sv
module txpend_split_reg
   import txpend_pkg::*;
#(
   parameter int                FLAG_W       = 32,
   parameter logic [FLAG_W-1:0] FLAG_PRESENT = 32'hFFFF_FFFE,
   localparam int               HALF_W       = FLAG_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_cs,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic              bus_word,
   input  logic [HALF_W-1:0] bus_wdata,
   output logic [HALF_W-1:0] bus_rdata,
   input  logic [FLAG_W-1:0] tx_dir,
   input  logic [FLAG_W-1:0] cancel_req,
   input  logic [FLAG_W-1:0] tx_done,
   output logic [FLAG_W-1:0] pend_flags
);

   if (FLAG_W % 2 != 0 || FLAG_W < 2) begin : g_bad_width
      $error("txpend_split_reg: FLAG_W must be even and at least 2");
   end

   logic [FLAG_W-1:0] set_vec;
   logic              set_en;
   logic [FLAG_W-1:0] clr_vec;

   assign clr_vec = cancel_req | tx_done;

   txpend_bus_port #(.FLAG_W(FLAG_W)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_cs    (bus_cs),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_word  (bus_word),
      .bus_wdata (bus_wdata),
      .flags     (pend_flags),
      .set_vec   (set_vec),
      .set_en    (set_en),
      .bus_rdata (bus_rdata)
   );

   txpend_flag_bank #(.FLAG_W(FLAG_W), .PRESENT(FLAG_PRESENT)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (set_en),
      .set_vec  (set_vec),
      .dir_mask (tx_dir),
      .clr_vec  (clr_vec),
      .flags    (pend_flags)
   );

endmodule

// File: rtl/txpend_split_reg_chk.sv
module txpend_split_reg_chk #(
   parameter int                FLAG_W  = 32,
   parameter logic [FLAG_W-1:0] PRESENT = 32'hFFFF_FFFE,
   localparam int               HALF_W  = FLAG_W / 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_cs,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic              bus_word,
   input logic [HALF_W-1:0] bus_rdata,
   input logic [FLAG_W-1:0] tx_dir,
   input logic [FLAG_W-1:0] cancel_req,
   input logic [FLAG_W-1:0] tx_done,
   input logic [FLAG_W-1:0] pend_flags
);

   assert_absent_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_flags & ~PRESENT) == '0);

   assert_upper_write_parks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cs && bus_wr && !bus_word && ((cancel_req | tx_done) == '0))
      |=> $stable(pend_flags));

   assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_flags & $past(cancel_req | tx_done)) == '0));

   assert_no_sw_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(pend_flags) & ~pend_flags & ~$past(cancel_req | tx_done)) == '0));

   assert_set_needs_lower_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_flags & ~$past(pend_flags)) != '0) |-> $past(bus_cs && bus_wr && bus_word));

   assert_dir_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_flags & ~$past(pend_flags) & ~$past(tx_dir)) == '0));

   assert_upper_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cs && bus_rd && !bus_wr && !bus_word)
      |=> (bus_rdata == $past(pend_flags[FLAG_W-1:HALF_W])));

   assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_cs && bus_rd) |=> $stable(bus_rdata));

endmodule

bind txpend_split_reg txpend_split_reg_chk #(.FLAG_W(FLAG_W), .PRESENT(FLAG_PRESENT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_cs     (bus_cs),
   .bus_rd     (bus_rd),
   .bus_wr     (bus_wr),
   .bus_word   (bus_word),
   .bus_rdata  (bus_rdata),
   .tx_dir     (tx_dir),
   .cancel_req (cancel_req),
   .tx_done    (tx_done),
   .pend_flags (pend_flags)
);

// File: tb/txpend_split_reg_tb_top.sv
module txpend_split_reg_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_cs = 1'b0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_word = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [31:0] tx_dir = '1;
   logic [31:0] cancel_req = '0;
   logic [31:0] tx_done = '0;
   logic [31:0] pend_flags;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   txpend_split_reg dut_i (
      .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_dir(tx_dir), .cancel_req(cancel_req), .tx_done(tx_done),
      .pend_flags(pend_flags)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one-cycle bus access; returns at the next falling edge
   task automatic access(input bit cs, input bit wr, input bit word, input logic [15:0] d);
      bus_cs = cs; bus_wr = wr; bus_rd = !wr; bus_word = word; bus_wdata = d;
      @(negedge clk);
      bus_cs = 0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
   endtask

   task automatic t_reset;
      check("R1 flags after reset", pend_flags, 32'h0);
      check("R1 rdata after reset", {16'h0, bus_rdata}, 32'h0);
      access(1, 0, 1, '0); // lower read returns latch reset value
      check("R1 latch after reset", {16'h0, bus_rdata}, 32'h0);
   endtask

   task automatic t_atomic_write;
      access(1, 1, 0, 16'hA5A5);
      check("R2 upper write parked", pend_flags, 32'h0);
      access(1, 1, 1, 16'h0F0F);
      check("R3 both halves applied, R10 bit0 ignored", pend_flags, 32'hA5A5_0F0E);
   endtask

   task automatic t_zero_write;
      access(1, 1, 0, 16'h0000);
      access(1, 1, 1, 16'h0000);
      check("R6 zero write keeps flags", pend_flags, 32'hA5A5_0F0E);
   endtask

   task automatic t_split_read;
      access(1, 0, 0, '0);
      check("R4 upper read", {16'h0, bus_rdata}, 32'h0000_A5A5);
      cancel_req = 32'h0000_0002;
      @(negedge clk);
      cancel_req = '0;
      check("R7 cancel clears", pend_flags, 32'hA5A5_0F0C);
      access(1, 0, 1, '0);
      check("R5 lower read returns snapshot, R10 bit0 zero", {16'h0, bus_rdata}, 32'h0000_0F0E);
      repeat (3) @(negedge clk);
      check("R12 rdata held", {16'h0, bus_rdata}, 32'h0000_0F0E);
   endtask

   task automatic t_done_clear;
      tx_done = 32'h0000_0100;
      @(negedge clk);
      tx_done = '0;
      check("R8 tx_done clears", pend_flags, 32'hA5A5_0E0C);
   endtask

   task automatic t_clear_wins;
      access(1, 1, 0, 16'h0000);
      cancel_req = 32'h0000_0010;
      access(1, 1, 1, 16'h0010);
      cancel_req = '0;
      check("R9 clear beats set", pend_flags, 32'hA5A5_0E0C);
   endtask

   task automatic t_dir_mask;
      tx_dir = 32'h0000_FFFF;
      access(1, 1, 0, 16'h0F00);
      access(1, 1, 1, 16'h00F0);
      tx_dir = '1;
      check("R11 masked upper dropped", pend_flags, 32'hA5A5_0EFC);
   endtask

   task automatic t_no_cs;
      access(0, 1, 1, 16'hFFFF);
      check("R13 write without cs ignored", pend_flags, 32'hA5A5_0EFC);
      access(0, 0, 0, '0);
      check("R13 read without cs ignored", {16'h0, bus_rdata}, 32'h0000_0F0E);
      access(1, 1, 0, 16'h0000);
      access(0, 1, 0, 16'hFFFF); // must not touch the latch
      access(1, 1, 1, 16'h0000);
      check("R13 latch untouched without cs", pend_flags, 32'hA5A5_0EFC);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_atomic_write();
      t_zero_write();
      t_split_read();
      t_done_clear();
      t_clear_wins();
      t_dir_mask();
      t_no_cs();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #40000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule